// File: doc/BRIEF.md
# DRAM Refresh and Background Scrub Sequencer

This block paces periodic DRAM refresh for a memory built from two banks, called block A and block B. A free-running interval timer raises a refresh request. The request is held until the DRAM timing engine grants the bus. Each granted burst then issues four row-strobe cycles, and every cycle strobes both blocks together.

One cycle of every burst also performs a scrub. In that cycle the block asserts the column strobe to a single selected block for two clocks. The first clock carries the output-enable phase and the second carries the write-enable phase, so the location is read and written back through the ECC path.

Over many bursts the block moves through the whole array. The row address advances after every cycle. Each time the row wraps, the scrub target flips between the two blocks. The scrub slot rotates on every second row wrap, and the column advances on every eighth row wrap. A 2-bit pass counter, readable by software, counts full column sweeps.

Top module: `refresh_scrub_seq`

## Requirements
- R1: With the fast bit clear, refresh requests are raised every INTERVAL clock cycles. `req_o` rises once per tick while grants are immediate.
- R2: With the fast bit set, the request period is INTERVAL/2 clock cycles.
- R3: A granted burst has exactly four row cycles. `ras_a_o` and `ras_b_o` are both high throughout the burst. The row address starts at the current row and rises by one after each cycle.
- R4: During the scrub cycle, the column strobe of only the target block is high for two clocks with the row address held. `oe_o` is high on the first clock and `we_o` on the second. In the other cycles `cas_a_o`, `cas_b_o`, `oe_o` and `we_o` stay low, and each non-scrub cycle lasts one clock.
- R5: The row address wraps from all ones to zero. Every row wrap toggles the scrub target. Target 0 is block A (column strobe on `cas_a_o`) and target 1 is block B.
- R6: On every second row wrap, the scrub slot moves to the next cycle of the burst: first to second, second to third, third to fourth, and fourth back to first.
- R7: On every eighth row wrap, the column address rises by one, wrapping from all ones to zero.
- R8: Every column wrap increments the 2-bit pass counter `sc_o`, which wraps modulo 4.
- R9: A request stays high until a burst starts on a grant, with no bursts while `grant_i` is low. Several ticks while waiting still yield a single burst.
- R10: After reset, the following are all zero: row, column, pass counter, request and all strobes. Block A is the first scrub target and the first cycle is the first scrub slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_i | input | 1 | Halves the refresh interval when set |
| grant_i | input | 1 | Bus grant from the DRAM timing engine |
| req_o | output | 1 | Pending refresh request |
| ras_a_o | output | 1 | Row strobe, block A |
| ras_b_o | output | 1 | Row strobe, block B |
| cas_a_o | output | 1 | Column strobe, block A (scrub) |
| cas_b_o | output | 1 | Column strobe, block B (scrub) |
| oe_o | output | 1 | Scrub read phase |
| we_o | output | 1 | Scrub write-back phase |
| row_o | output | ROW_W | Refresh/scrub row address |
| col_o | output | COL_W | Scrub column address |
| sc_o | output | 2 | Scrub pass counter |

## Verification
Two functions can fall on the same clock: a row wrap that toggles the target, and the column advance and pass-counter increment that belong to the same step. All of these updates hang off the final row step of a burst. The bench provokes the overlap with two-bit row and column widths, so that every burst ends on a row wrap and the column and pass counter roll over on bursts 31 and 63. A scoreboard predicts every strobe clock of 70 bursts from the burst index alone and judges each one by comparing it with the ports.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned SLOTS  = 4;
  localparam int unsigned SLOT_W = 2;
  localparam int unsigned WRAP_W = 3;
  localparam int unsigned SC_W   = 2;

  typedef enum logic {
    BLK_A = 1'b0,
    BLK_B = 1'b1
  } blk_e;

  typedef enum logic {
    PH_READ  = 1'b0,
    PH_WRITE = 1'b1
  } scrub_ph_e;
endpackage

// File: rtl/rs_interval_timer.sv
module rs_interval_timer #(
  parameter int unsigned INTERVAL = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic fast,
  output logic tick
);
  localparam int unsigned CNT_W = $clog2(INTERVAL + 1);
  localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(INTERVAL - 1);
  localparam logic [CNT_W-1:0] LIM_FAST = CNT_W'(INTERVAL / 2 - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb lim = fast ? LIM_FAST : LIM_SLOW;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + CNT_W'(1);
      tick <= 1'b0;
    end
  end

  // R1: a tick is a single-clock pulse
  a_r1_tick_pulse: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/rs_addr_gen.sv
module rs_addr_gen
  import rs_pkg::*;
#(
  parameter int unsigned ROW_W = 10,
  parameter int unsigned COL_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output blk_e              blk,
  output logic [SLOT_W-1:0] slot,
  output logic [SC_W-1:0]   sc
);
  localparam logic [ROW_W-1:0]  ROW_MAX  = '1;
  localparam logic [COL_W-1:0]  COL_MAX  = '1;
  localparam logic [WRAP_W-1:0] WRAP_MAX = '1;

  logic [WRAP_W-1:0] wraps;
  logic              row_wrap;
  logic              col_adv;

  always_comb begin
    row_wrap = step && (row == ROW_MAX);
    col_adv  = row_wrap && (wraps == WRAP_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row   <= '0;
      col   <= '0;
      blk   <= BLK_A;
      slot  <= '0;
      sc    <= '0;
      wraps <= '0;
    end else begin
      if (step) row <= row + ROW_W'(1);
      if (row_wrap) begin
        wraps <= wraps + WRAP_W'(1);
        blk   <= (blk == BLK_A) ? BLK_B : BLK_A;
        if (wraps[0]) slot <= slot + SLOT_W'(1);
      end
      if (col_adv) begin
        col <= col + COL_W'(1);
        if (col == COL_MAX) sc <= sc + SC_W'(1);
      end
    end
  end

  // R3: each step advances the row by one
  a_r3_row_step: assert property (@(posedge clk) disable iff (rst)
    step |=> (row == $past(row) + ROW_W'(1)));
  // R5: a row wrap flips the scrub target
  a_r5_blk_toggle: assert property (@(posedge clk) disable iff (rst)
    (step && row == ROW_MAX) |=> (blk != $past(blk)));
  // R6: without a row wrap the slot holds
  a_r6_slot_hold: assert property (@(posedge clk) disable iff (rst)
    !(step && row == ROW_MAX) |=> $stable(slot));
  // R7: the column only moves when the row wraps
  a_r7_col_hold: assert property (@(posedge clk) disable iff (rst)
    !(step && row == ROW_MAX) |=> $stable(col));
  // R8: the pass counter only moves when the column does
  a_r8_sc_follows_col: assert property (@(posedge clk) disable iff (rst)
    $stable(col) |-> $stable(sc));
endmodule

// File: rtl/rs_burst_fsm.sv
module rs_burst_fsm
  import rs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              grant,
  input  logic [SLOT_W-1:0] slot,
  input  blk_e              blk,
  output logic              req,
  output logic              step,
  output logic              ras,
  output logic              cas_a,
  output logic              cas_b,
  output logic              oe,
  output logic              we
);
  localparam logic [SLOT_W-1:0] LAST_CYC = SLOT_W'(SLOTS - 1);

  logic              busy;
  logic [SLOT_W-1:0] cyc;
  scrub_ph_e         ph;
  logic              start;
  logic              is_scrub;

  always_comb begin
    start    = !busy && req && grant;
    is_scrub = busy && (cyc == slot);
    step     = busy && (!is_scrub || ph == PH_WRITE);
    ras      = busy;
    cas_a    = is_scrub && (blk == BLK_A);
    cas_b    = is_scrub && (blk == BLK_B);
    oe       = is_scrub && (ph == PH_READ);
    we       = is_scrub && (ph == PH_WRITE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req  <= 1'b0;
      busy <= 1'b0;
      cyc  <= '0;
      ph   <= PH_READ;
    end else begin
      if (tick)       req <= 1'b1;
      else if (start) req <= 1'b0;

      if (start) begin
        busy <= 1'b1;
        cyc  <= '0;
        ph   <= PH_READ;
      end else if (busy) begin
        if (is_scrub && ph == PH_READ) begin
          ph <= PH_WRITE;
        end else begin
          ph <= PH_READ;
          if (cyc == LAST_CYC) busy <= 1'b0;
          else                 cyc  <= cyc + SLOT_W'(1);
        end
      end
    end
  end

  // R9: a pending request persists until a burst starts
  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    (req && !(busy == 1'b0 && grant)) |=> req);
  // R4: the read phase is always followed by the write phase
  a_r4_oe_then_we: assert property (@(posedge clk) disable iff (rst)
    oe |=> (we && $stable(cas_a) && $stable(cas_b)));
  // R4: at most one block gets a column strobe
  a_r4_one_cas: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cas_a, cas_b}));
  // R4: column strobes only inside a row cycle
  a_r4_cas_in_ras: assert property (@(posedge clk) disable iff (rst)
    (cas_a || cas_b) |-> ras);
endmodule

// File: rtl/refresh_scrub_seq.sv
module refresh_scrub_seq
  import rs_pkg::*;
#(
  parameter int unsigned ROW_W    = 10,
  parameter int unsigned COL_W    = 10,
  parameter int unsigned INTERVAL = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fast_i,
  input  logic             grant_i,
  output logic             req_o,
  output logic             ras_a_o,
  output logic             ras_b_o,
  output logic             cas_a_o,
  output logic             cas_b_o,
  output logic             oe_o,
  output logic             we_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic [1:0]       sc_o
);
  logic              tick;
  logic              step;
  logic              ras;
  logic [SLOT_W-1:0] slot;
  blk_e              blk;

  rs_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .fast (fast_i),
    .tick (tick)
  );

  rs_burst_fsm u_fsm (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .grant (grant_i),
    .slot  (slot),
    .blk   (blk),
    .req   (req_o),
    .step  (step),
    .ras   (ras),
    .cas_a (cas_a_o),
    .cas_b (cas_b_o),
    .oe    (oe_o),
    .we    (we_o)
  );

  rs_addr_gen #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
    .clk  (clk),
    .rst  (rst),
    .step (step),
    .row  (row_o),
    .col  (col_o),
    .blk  (blk),
    .slot (slot),
    .sc   (sc_o)
  );

  always_comb begin
    ras_a_o = ras;
    ras_b_o = ras;
  end

  // R10: nothing is strobed while in reset
  a_r10_quiet_reset: assert property (@(posedge clk)
    $past(rst) |-> !(ras_a_o || cas_a_o || cas_b_o || req_o));
endmodule

// File: tb/tb_refresh_scrub_seq.sv
module tb_refresh_scrub_seq;
  localparam int ROW_W = 2;
  localparam int COL_W = 2;
  localparam int IV    = 16;
  localparam int NB    = 70;

  logic clk = 1'b0;
  logic rst, fast_i, grant_i;
  logic req_o, ras_a_o, ras_b_o, cas_a_o, cas_b_o, oe_o, we_o;
  logic [ROW_W-1:0] row_o;
  logic [COL_W-1:0] col_o;
  logic [1:0] sc_o;

  always #4 clk = ~clk;

  refresh_scrub_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .INTERVAL(IV)) dut (
    .clk(clk), .rst(rst), .fast_i(fast_i), .grant_i(grant_i), .req_o(req_o),
    .ras_a_o(ras_a_o), .ras_b_o(ras_b_o), .cas_a_o(cas_a_o), .cas_b_o(cas_b_o),
    .oe_o(oe_o), .we_o(we_o), .row_o(row_o), .col_o(col_o), .sc_o(sc_o));

  int checks = 0, fails = 0;
  int ec = 0;
  int bursts = 0, rises = 0, last_rise = 0, prev_rise = 0;
  logic prev_ras = 1'b0, prev_req = 1'b0;
  logic [11:0] expq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // item: {ras_b, row, col, sc, cas_a, cas_b, oe, we}
  task automatic push_burst(input int k);
    int blk  = k % 2;
    int slot = (k / 2) % 4;
    int col  = (k / 8) % 4;
    int sc   = (k / 32) % 4;
    for (int c = 0; c < 4; c++) begin
      if (c == slot) begin
        expq.push_back({1'b1, 2'(c), 2'(col), 2'(sc), blk == 0, blk == 1, 1'b1, 1'b0});
        expq.push_back({1'b1, 2'(c), 2'(col), 2'(sc), blk == 0, blk == 1, 1'b0, 1'b1});
      end else begin
        expq.push_back({1'b1, 2'(c), 2'(col), 2'(sc), 4'b0000});
      end
    end
  endtask

  always @(posedge clk) begin
    if (rst) ec <= 0;
    else     ec <= ec + 1;
  end

  // monitor: scoreboard pop and event tracking
  always @(negedge clk) begin
    if (!rst) begin
      if (ras_a_o) begin
        logic [11:0] got, exp;
        got = {ras_b_o, row_o, col_o, sc_o, cas_a_o, cas_b_o, oe_o, we_o};
        if (expq.size() == 0) begin
          chk(1'b0, "R3 unexpected row cycle", int'(got), 0);
        end else begin
          exp = expq.pop_front();
          // R3 R4 R5 R6 R7 R8 per-clock strobe and address prediction
          chk(got == exp, $sformatf("R3/R4 R5 R6 R7 R8 burst %0d", bursts),
              int'(got), int'(exp));
        end
      end else begin
        chk(!(cas_a_o || cas_b_o || oe_o || we_o), "R4 strobe outside burst",
            int'({cas_a_o, cas_b_o, oe_o, we_o}), 0);
      end
      if (prev_ras && !ras_a_o) bursts <= bursts + 1;
      if (req_o && !prev_req) begin
        prev_rise <= last_rise;
        last_rise <= ec;
        rises     <= rises + 1;
      end
      prev_ras <= ras_a_o;
      prev_req <= req_o;
    end
  end

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    rst = 1'b1; fast_i = 1'b0; grant_i = 1'b0;
    for (int k = 0; k < NB + 2; k++) push_burst(k);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(req_o == 0 && ras_a_o == 0 && ras_b_o == 0, "R10 strobes/req", int'({req_o, ras_a_o}), 0);
    chk(row_o == 0 && col_o == 0 && sc_o == 0, "R10 addresses", int'({row_o, col_o, sc_o}), 0);
    rst = 1'b0;

    // R9 hold without grant across several ticks
    while (ec < 3 * IV + 5) @(negedge clk);
    chk(req_o == 1'b1, "R9 request held", int'(req_o), 1);
    chk(bursts == 0 && ras_a_o == 0, "R9 no burst without grant", bursts, 0);
    while (ec % IV != 3) @(negedge clk);
    grant_i = 1'b1;
    while (bursts < 1) @(posedge clk);
    @(negedge clk);
    chk(req_o == 1'b0, "R9 single pending flag", int'(req_o), 0);
    repeat (IV - 8) @(negedge clk);
    chk(bursts == 1, "R9 one burst for many ticks", bursts, 1);

    // R1 slow period
    for (int i = 0; i < 3; i++) begin
      n = rises;
      while (rises == n) @(posedge clk);
      if (i > 0) chk(last_rise - prev_rise == IV, "R1 interval", last_rise - prev_rise, IV);
    end

    // R2 fast period
    @(negedge clk);
    fast_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      n = rises;
      while (rises == n) @(posedge clk);
      if (i > 1) chk(last_rise - prev_rise == IV / 2, "R2 fast interval", last_rise - prev_rise, IV / 2);
    end

    while (bursts < NB) @(posedge clk);
    @(negedge clk);
    // R8 two column sweeps done after 64 bursts
    chk(sc_o == 2'd2, "R8 pass counter", int'(sc_o), 2);
    chk(col_o == 2'((NB / 8) % 4), "R7 column position", int'(col_o), (NB / 8) % 4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule